// File: doc/BRIEF.md
# PLL Retune Sequencer

This block carries out the safe retuning of a phase-locked loop through a plain register access port. A host gives it a new feedback-divider word and a one-cycle start command. The sequencer first reads the PLL control register. It then writes control back with the power-down bit set and the bypass, both direct-path and clock-enable bits cleared, leaving every other bit as it was. Next it writes the new divider word to the multiplier register and a fixed value, which sets the pre- and post-dividers to one, to the pre/post-divider register. Finally it writes control again with power-down cleared.

After power-up the sequencer waits a fixed time of 10 µs, measured in clock cycles, and then reads the status register, whose bit 0 reports lock. It does this up to four times. On the first locked reading it sets clock enable in control and finishes cleanly. If all four readings show no lock, it finishes with an error and leaves clock enable cleared. Each register access uses a request that is held until a one-cycle acknowledge. The sequencer takes no further step until that acknowledge arrives.

Top module: `pll_seq_top`

## Requirements
- R1: After reset, busy, done, err and regReq are all low.
- R2: The first access of a sequence is a read of control (address CTRL_ADDR). The next is a write of control in which bit 0 (power-down) is set, bits 1 to 4 (bypass, direct-input, direct-output, clock enable) are cleared and all other bits equal the value read. No write to control ever has bits 1 to 3 set.
- R3: The third access writes the divider word captured at start to address CTRL_ADDR+4. Later changes on divWord have no effect.
- R4: The fourth access writes 0x00302062 to address CTRL_ADDR+8.
- R5: The fifth access writes control with the value of the R2 write, except that bit 0 is cleared.
- R6: Every read of status (address CTRL_ADDR-4) comes at least WAIT_CYCLES = CLK_MHZ*WAIT_US clock cycles after the acknowledge of the access before it.
- R7: Status bit 0 means locked, and the other status bits are ignored. On the first locked reading, control is written with the R5 value plus bit 4 set. Then done pulses with err low.
- R8: If four status readings in a row show no lock, no further write follows, control keeps bit 4 clear, and done and err pulse together.
- R9: busy is high from the cycle after an accepted start until done, and low in the done cycle. A start while busy is ignored.
- R10: regReq, regWe, regAddr and regWdata stay stable until regAck. Each acknowledged access moves the sequence on by exactly one step.
- R11: done and err are each high for exactly one cycle per sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start a retune (taken when idle) |
| divWord | input | DATA_W | New multiplier register value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | One-cycle lock-failure pulse, with done |
| regReq | output | 1 | Register access request |
| regWe | output | 1 | 1 = write, 0 = read |
| regAddr | output | ADDR_W | Register address |
| regWdata | output | DATA_W | Write data |
| regAck | input | 1 | One-cycle access acknowledge |
| regRdata | input | DATA_W | Read data, valid with regAck |

## Verification
The hardest case to reach from the ports is lock arriving only on the fourth and last poll, or never arriving. Reaching it needs a PLL that stays unlocked across several timed waits. The bench models the PLL as a status register that returns a chosen number of unlocked readings before it reports lock. The unlocked readings have every bit except bit 0 set. The bench also varies the acknowledge latency from one request to the next, and it issues a second start in the middle of a sequence to show that this start is ignored.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int PD_BIT    = 0;
  localparam int BYP_BIT   = 1;
  localparam int DIN_BIT   = 2;
  localparam int DOUT_BIT  = 3;
  localparam int CEN_BIT   = 4;
  localparam int LOCK_BIT  = 0;

  typedef enum logic [3:0] {
    S_IDLE, S_RDCTL, S_PWRDN, S_MDIV, S_NPDIV, S_PWRUP, S_WAIT, S_RDSTAT, S_ENABLE
  } seqState_e;

  typedef enum logic [2:0] {W_PD, W_DIV, W_NP, W_PU, W_EN} wSel_e;
  typedef enum logic [1:0] {A_CTRL, A_MDIV, A_NP, A_STAT} aSel_e;

  typedef struct packed {
    logic  capCtrl;
    logic  capDiv;
    logic  armWait;
    logic  clrPoll;
    logic  bumpPoll;
    wSel_e wSel;
    aSel_e aSel;
  } seqStrobe_t;
endpackage

// File: rtl/pll_seq_dp.sv
module pll_seq_dp import pll_seq_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h30,
  parameter logic [DATA_W-1:0] NP_UNITY = 32'h0030_2062,
  parameter int WAIT_CYCLES = 2500,
  parameter int POLL_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [DATA_W-1:0] divWord,
  input  logic [DATA_W-1:0] regRdata,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              waitDone,
  output logic              pollLast,
  output logic              lockSeen
);
  localparam int WW = $clog2(WAIT_CYCLES + 1);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [DATA_W-1:0] PD_MASK  = DATA_W'(1) << PD_BIT;
  localparam logic [DATA_W-1:0] CEN_MASK = DATA_W'(1) << CEN_BIT;
  localparam logic [DATA_W-1:0] CLR_MASK = (DATA_W'(1) << BYP_BIT) | (DATA_W'(1) << DIN_BIT)
                                         | (DATA_W'(1) << DOUT_BIT) | CEN_MASK;

  logic [DATA_W-1:0] ctrlQ, divQ, pdVal, puVal;
  logic [WW-1:0]     waitCnt;
  logic [PW-1:0]     pollCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      divQ    <= '0;
      waitCnt <= '0;
      pollCnt <= '0;
    end else begin
      if (strb.capCtrl) ctrlQ <= regRdata;
      if (strb.capDiv)  divQ  <= divWord;
      if (strb.armWait)           waitCnt <= WW'(WAIT_CYCLES - 1);
      else if (waitCnt != '0)     waitCnt <= waitCnt - 1'b1;
      if (strb.clrPoll)           pollCnt <= '0;
      else if (strb.bumpPoll)     pollCnt <= pollCnt + 1'b1;
    end
  end

  assign pdVal    = (ctrlQ | PD_MASK) & ~CLR_MASK;
  assign puVal    = pdVal & ~PD_MASK;
  assign waitDone = (waitCnt == '0);
  assign pollLast = (pollCnt == PW'(POLL_LIMIT - 1));
  assign lockSeen = regRdata[LOCK_BIT];

  always_comb begin
    unique case (strb.wSel)
      W_PD:    regWdata = pdVal;
      W_DIV:   regWdata = divQ;
      W_NP:    regWdata = NP_UNITY;
      W_PU:    regWdata = puVal;
      W_EN:    regWdata = puVal | CEN_MASK;
      default: regWdata = puVal;
    endcase
    unique case (strb.aSel)
      A_CTRL:  regAddr = CTRL_ADDR;
      A_MDIV:  regAddr = CTRL_ADDR + ADDR_W'(4);
      A_NP:    regAddr = CTRL_ADDR + ADDR_W'(8);
      A_STAT:  regAddr = CTRL_ADDR - ADDR_W'(4);
      default: regAddr = CTRL_ADDR;
    endcase
  end

  // R7
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt <= PW'(POLL_LIMIT));

  // R6
  wait_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.armWait |=> !waitDone);
endmodule

// File: rtl/pll_seq_ctl.sv
module pll_seq_ctl import pll_seq_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       regAck,
  input  logic       waitDone,
  input  logic       pollLast,
  input  logic       lockSeen,
  output seqStrobe_t strb,
  output logic       regReq,
  output logic       regWe,
  output logic       busy,
  output logic       done,
  output logic       err
);
  seqState_e st, nxt;
  logic finOk, finErr;

  always_comb begin
    nxt           = st;
    strb.capCtrl  = 1'b0;
    strb.capDiv   = 1'b0;
    strb.armWait  = 1'b0;
    strb.clrPoll  = 1'b0;
    strb.bumpPoll = 1'b0;
    strb.wSel     = W_PD;
    strb.aSel     = A_CTRL;
    regReq        = 1'b0;
    regWe         = 1'b0;
    finOk         = 1'b0;
    finErr        = 1'b0;
    unique case (st)
      S_IDLE: if (start) begin
        strb.capDiv = 1'b1;
        nxt = S_RDCTL;
      end
      S_RDCTL: begin
        regReq = 1'b1;
        if (regAck) begin strb.capCtrl = 1'b1; nxt = S_PWRDN; end
      end
      S_PWRDN: begin
        regReq = 1'b1; regWe = 1'b1; strb.wSel = W_PD;
        if (regAck) nxt = S_MDIV;
      end
      S_MDIV: begin
        regReq = 1'b1; regWe = 1'b1; strb.wSel = W_DIV; strb.aSel = A_MDIV;
        if (regAck) nxt = S_NPDIV;
      end
      S_NPDIV: begin
        regReq = 1'b1; regWe = 1'b1; strb.wSel = W_NP; strb.aSel = A_NP;
        if (regAck) nxt = S_PWRUP;
      end
      S_PWRUP: begin
        regReq = 1'b1; regWe = 1'b1; strb.wSel = W_PU;
        if (regAck) begin strb.armWait = 1'b1; strb.clrPoll = 1'b1; nxt = S_WAIT; end
      end
      S_WAIT: if (waitDone) nxt = S_RDSTAT;
      S_RDSTAT: begin
        regReq = 1'b1; strb.aSel = A_STAT;
        if (regAck) begin
          strb.bumpPoll = 1'b1;
          if (lockSeen)      nxt = S_ENABLE;
          else if (pollLast) begin finErr = 1'b1; nxt = S_IDLE; end
          else begin strb.armWait = 1'b1; nxt = S_WAIT; end
        end
      end
      S_ENABLE: begin
        regReq = 1'b1; regWe = 1'b1; strb.wSel = W_EN;
        if (regAck) begin finOk = 1'b1; nxt = S_IDLE; end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st   <= S_IDLE;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      st   <= nxt;
      done <= finOk | finErr;
      err  <= finErr;
    end
  end

  assign busy = (st != S_IDLE);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R8
  err_done_chk: assert property (@(posedge clk) disable iff (!rstN) err |-> done);
  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regAck) |=> (regReq && $stable(regWe)));
endmodule

// File: rtl/pll_seq_top.sv
module pll_seq_top import pll_seq_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h30,
  parameter logic [DATA_W-1:0] NP_UNITY = 32'h0030_2062,
  parameter int CLK_MHZ = 250,
  parameter int WAIT_US = 10,
  parameter int POLL_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] divWord,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              regReq,
  output logic              regWe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  input  logic              regAck,
  input  logic [DATA_W-1:0] regRdata
);
  localparam int WAIT_CYCLES = CLK_MHZ * WAIT_US;

  seqStrobe_t strb;
  logic waitDone, pollLast, lockSeen;

  pll_seq_ctl uCtl (
    .clk(clk), .rstN(rstN), .start(start), .regAck(regAck),
    .waitDone(waitDone), .pollLast(pollLast), .lockSeen(lockSeen),
    .strb(strb), .regReq(regReq), .regWe(regWe),
    .busy(busy), .done(done), .err(err)
  );

  pll_seq_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .NP_UNITY(NP_UNITY),
    .WAIT_CYCLES(WAIT_CYCLES), .POLL_LIMIT(POLL_LIMIT)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .divWord(divWord), .regRdata(regRdata),
    .regAddr(regAddr), .regWdata(regWdata),
    .waitDone(waitDone), .pollLast(pollLast), .lockSeen(lockSeen)
  );

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regAck) |=> ($stable(regAddr) && $stable(regWdata)));
  // R2
  ctl_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && regWe && regAddr == CTRL_ADDR) |-> (regWdata[DOUT_BIT:BYP_BIT] == '0));
endmodule

// File: tb/sim_pll_seq_top.sv
`timescale 1ns/1ps
module sim_pll_seq_top;
  localparam int W = 2500;
  localparam logic [7:0] CA = 8'h30;
  localparam logic [31:0] NPV = 32'h0030_2062;
  // {divWord, initial control, unlocked readings before lock (4 = never)}
  localparam logic [67:0] VEC [5] = '{
    {32'h0001_4A35, 32'h0000_0000, 4'd0},
    {32'h0FFF_FFFF, 32'hFFFF_FFFF, 4'd1},
    {32'h0010_0203, 32'h1234_5676, 4'd3},
    {32'h0002_0BEE, 32'hA5A5_5A5E, 4'd4},
    {32'h0000_0001, 32'h0000_001E, 4'd2}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0, start = 1'b0, regAck = 1'b0;
  logic [31:0] divWord = '0, regRdata = '0;
  logic busy, done, err, regReq, regWe;
  logic [7:0] regAddr;
  logic [31:0] regWdata;

  pll_seq_top u0 (
    .clk(clk), .rstN(rstN), .start(start), .divWord(divWord),
    .busy(busy), .done(done), .err(err),
    .regReq(regReq), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regAck(regAck), .regRdata(regRdata)
  );

  int total = 0, bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bench-side register model
  logic [31:0] ctrlReg;
  int lockAfter, nStat, nWr, reqNo, latLeft, lastMark, minGap, holdBad, nReq;
  logic [7:0]  wAddr [8];
  logic [31:0] wData [8];
  logic [7:0]  firstAddr, pAddr;
  logic        firstWe, pWe, pend;
  logic [31:0] pData;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rstN) begin
      regAck = 1'b0; pend = 1'b0;
    end else if (regAck) begin
      regAck = 1'b0;
    end else if (regReq) begin
      if (!pend) begin
        pend = 1'b1; pAddr = regAddr; pWe = regWe; pData = regWdata;
        latLeft = reqNo % 3; reqNo++;
        if (nReq == 0) begin firstAddr = regAddr; firstWe = regWe; end
        nReq++;
        if (!regWe && regAddr == CA - 8'd4 && (cyc - lastMark) < minGap)
          minGap = cyc - lastMark;
      end else if (regAddr != pAddr || regWe != pWe || (pWe && regWdata != pData)) begin
        holdBad++;
      end
      if (latLeft == 0) begin
        regAck = 1'b1; pend = 1'b0; lastMark = cyc;
        if (pWe) begin
          if (nWr < 8) begin wAddr[nWr] = pAddr; wData[nWr] = pData; end
          nWr++;
          if (pAddr == CA) ctrlReg = pData;
        end else if (pAddr == CA) begin
          regRdata = ctrlReg;
        end else if (pAddr == CA - 8'd4) begin
          regRdata = (nStat < lockAfter) ? 32'hFFFF_FFFE : 32'h0000_0001;
          nStat++;
        end else begin
          regRdata = '0;
        end
      end else begin
        latLeft--;
      end
    end
  end

  task automatic runSeq(input logic [31:0] dv, input logic [31:0] c0, input int la,
                        input bit dbl, input string tag);
    logic [31:0] e0, e3;
    int t, drop, nw, ns;
    bit expErr;
    ctrlReg = c0; lockAfter = la; nStat = 0; nWr = 0; nReq = 0;
    minGap = 1 << 30; holdBad = 0; drop = 0;
    expErr = (la >= 4);
    e0 = (c0 | 32'h1) & ~32'h1E;
    e3 = e0 & ~32'h1;
    nw = expErr ? 4 : 5;
    ns = expErr ? 4 : la + 1;
    @(negedge clk); start = 1'b1; divWord = dv;
    @(negedge clk); start = 1'b0; divWord = ~dv;
    chk(busy == 1'b1, "R9", {tag, " busy after start"}, 32'(busy), 32'd1);
    t = 0;
    while (!done && t < 30000) begin
      if (!busy) drop++;
      if (dbl && t == 3) begin start = 1'b1; divWord = 32'h5A5A_5A5A; end
      else if (dbl && t == 4) start = 1'b0;
      @(negedge clk); t++;
    end
    start = 1'b0;
    chk(done == 1'b1, "R11", {tag, " done seen"}, 32'(done), 32'd1);
    chk(busy == 1'b0 && drop == 0, "R9", {tag, " busy span"}, 32'(drop), 32'd0);
    chk(err == expErr, expErr ? "R8" : "R7", {tag, " err flag"}, 32'(err), 32'(expErr));
    chk(firstAddr == CA && firstWe == 1'b0, "R2", {tag, " first access"},
        {23'd0, firstWe, firstAddr}, {24'd0, CA});
    chk(nWr == nw, "R9", {tag, " write count"}, 32'(nWr), 32'(nw));
    chk(wAddr[0] == CA && wData[0] == e0, "R2", {tag, " power-down write"}, wData[0], e0);
    chk(wAddr[1] == CA + 8'd4 && wData[1] == dv, "R3", {tag, " divider write"}, wData[1], dv);
    chk(wAddr[2] == CA + 8'd8 && wData[2] == NPV, "R4", {tag, " np write"}, wData[2], NPV);
    chk(wAddr[3] == CA && wData[3] == e3, "R5", {tag, " power-up write"}, wData[3], e3);
    if (!expErr)
      chk(wAddr[4] == CA && wData[4] == (e3 | 32'h10), "R7", {tag, " enable write"},
          wData[4], e3 | 32'h10);
    else
      chk(ctrlReg[4] == 1'b0, "R8", {tag, " clock enable clear"}, ctrlReg, e3);
    chk(nStat == ns, "R7", {tag, " status reads"}, 32'(nStat), 32'(ns));
    chk(minGap >= W, "R6", {tag, " wait before poll"}, 32'(minGap), 32'(W));
    chk(holdBad == 0, "R10", {tag, " request hold"}, 32'(holdBad), 32'd0);
    @(negedge clk);
    chk(done == 1'b0 && err == 1'b0, "R11", {tag, " pulse width"},
        {30'd0, done, err}, 32'd0);
  endtask

  initial begin
    reqNo = 0; nReq = 0; lastMark = 0;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !err && !regReq, "R1", "reset state",
        {28'd0, busy, done, err, regReq}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !regReq, "R1", "idle after reset", {30'd0, busy, regReq}, 32'd0);
    for (int i = 0; i < 5; i++)
      runSeq(VEC[i][67:36], VEC[i][35:4], int'(VEC[i][3:0]), 1'b0, $sformatf("vec%0d", i));
    // R9 start while busy is ignored; R3 divider captured at start
    runSeq(32'h0003_3333, 32'h0000_00E1, 0, 1'b1, "dblstart");
    // R8 lock never seen, start while busy during the failing run
    runSeq(32'h0000_7777, 32'hFFFF_FFE0, 4, 1'b1, "dblfail");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 190000);
    bad++; total++;
    $display("FAIL watchdog R10 actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule